// File: doc/BRIEF.md
# Dual-DAC Serial Latch Controller

This block is the digital front end of a dual 10-bit DAC. A host shifts a 16-bit command word into it over a three-wire serial port: an active-low select, a serial clock and a data line. The block takes the four most significant bits as program bits. It routes the 10-bit code field into one of three holding registers: the channel A latch, the channel B latch, or a staging latch that can feed channel B. It also registers a settling-speed select and a power-down flag.

All logic runs on a system clock. The serial pins are synchronised and edge-detected in that clock domain, so the serial clock must stay at or below a quarter of the system clock rate. The staging latch lets both channels change together. The host first loads the staging latch alone, then performs a channel A write. That single transfer loads A from the serial word and copies the staging latch into B in the same cycle.

Top module: `dacfe_top`

## Requirements
- R1: Data is shifted MSB first, one bit on each rising serial-clock edge while select is low. The code field is word bits 11 down to 2, and bits 1 and 0 are ignored.
- R2: With word bit 15 set, a transfer loads latch A from the code field and loads latch B from the staging latch. The staging latch keeps its value and bit 12 has no effect.
- R3: With bit 15 clear and bit 12 clear, a transfer loads both latch B and the staging latch from the code field. Latch A keeps its value.
- R4: With bit 15 clear and bit 12 set, a transfer loads only the staging latch. Both DAC code outputs stay unchanged.
- R5: Word bit 14 sets `fastSettle` on each transfer: 1 selects fast settling and 0 selects slow settling.
- R6: Word bit 13 sets `powerDown` on each transfer: 1 means powered down and 0 means active. Power-down never alters the latches, so the codes present before power-down are still on the outputs after it is released.
- R7: A transfer fires on the 16th rising serial-clock edge of a frame. Further edges in that frame are ignored, and so is the select rise that ends it.
- R8: If select rises after 1 to 15 bits, a transfer fires on the received bits read as a right-aligned integer. If select rises with no bits received, nothing is transferred. A falling select restarts the bit count.
- R9: Reset clears latch A, latch B and the staging latch to zero, selects slow settling and selects the active (not powered-down) state.
- R10: Between transfers, the codes, `fastSettle` and `powerDown` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selN | input | 1 | Serial select, active low |
| serClk | input | 1 | Serial clock, data sampled on its rising edge |
| serDin | input | 1 | Serial data, MSB first |
| codeA | output | DATA_W (10) | Channel A DAC code |
| codeB | output | DATA_W (10) | Channel B DAC code |
| fastSettle | output | 1 | 1 = fast settling, 0 = slow settling |
| powerDown | output | 1 | 1 = powered down |

## Verification
The bench builds the block with its default parameters: a 16-bit frame, a 10-bit code and two synchroniser stages. With these values the 16th-edge trigger, the ignored trailing edges and short frames from zero to fifteen bits can all be driven with ordinary serial timing. A serial half-period of four system clocks leaves the synchroniser and edge detector enough margin. With it, every ordering of staging, channel A and channel B writes, including writes that combine power-down or speed changes, can be compared against a reference model.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  // Strobes sent by the serial controller to the latch datapath.
  typedef struct packed {
    logic xfer;       // a transfer happens this cycle
    logic wrA;        // load latch A from the code field
    logic wrB;        // load latch B from the code field
    logic wrStage;    // load the staging latch from the code field
    logic bFromStage; // load latch B from the staging latch
    logic fast;       // settling speed to register
    logic pd;         // power-down level to register
  } dacfe_stb_t;

endpackage

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              serClk,
  input  logic              serDin,
  output dacfe_stb_t        stb,
  output logic [DATA_W-1:0] code
);

  localparam int CNT_W    = $clog2(FRAME_BITS + 1);
  localparam int CODE_MSB = FRAME_BITS - 5;
  localparam int CODE_LSB = CODE_MSB - DATA_W + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  // Synchronisers for the serial pins.
  logic [SYNC_STAGES-1:0] selSh, clkSh, dinSh;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          selSh <= '1;
          clkSh <= '0;
          dinSh <= '0;
        end else begin
          selSh <= selN;
          clkSh <= serClk;
          dinSh <= serDin;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          selSh <= '1;
          clkSh <= '0;
          dinSh <= '0;
        end else begin
          selSh <= {selSh[SYNC_STAGES-2:0], selN};
          clkSh <= {clkSh[SYNC_STAGES-2:0], serClk};
          dinSh <= {dinSh[SYNC_STAGES-2:0], serDin};
        end
      end
    end
  endgenerate

  logic selS, clkS, dinS;
  assign selS = selSh[SYNC_STAGES-1];
  assign clkS = clkSh[SYNC_STAGES-1];
  assign dinS = dinSh[SYNC_STAGES-1];

  logic selPrev, clkPrev;
  logic clkRise, selRise, selFall;
  assign clkRise = clkS & ~clkPrev;
  assign selRise = selS & ~selPrev;
  assign selFall = ~selS & selPrev;

  logic [FRAME_BITS-1:0] shiftQ, wordNext, fireWord;
  logic [CNT_W-1:0]      cntQ;
  logic                  doneQ;
  logic                  shiftEn, fireNow;

  assign wordNext = {shiftQ[FRAME_BITS-2:0], dinS};
  assign shiftEn  = !selFall && !selS && clkRise && !doneQ;

  always_comb begin
    fireNow  = 1'b0;
    fireWord = shiftQ;
    if (shiftEn && cntQ == LAST_BIT) begin
      fireNow  = 1'b1;
      fireWord = wordNext;
    end else if (selRise && !doneQ && cntQ != '0) begin
      fireNow = 1'b1;
    end
  end

  logic b15, b14, b13, b12;
  assign b15 = fireWord[FRAME_BITS-1];
  assign b14 = fireWord[FRAME_BITS-2];
  assign b13 = fireWord[FRAME_BITS-3];
  assign b12 = fireWord[FRAME_BITS-4];

  logic [CODE_LSB-1:0] unusedLow;
  assign unusedLow = fireWord[CODE_LSB-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev <= 1'b1;
      clkPrev <= 1'b0;
      shiftQ  <= '0;
      cntQ    <= '0;
      doneQ   <= 1'b0;
    end else begin
      selPrev <= selS;
      clkPrev <= clkS;
      if (selFall) begin
        shiftQ <= '0;
        cntQ   <= '0;
        doneQ  <= 1'b0;
      end else if (shiftEn) begin
        shiftQ <= wordNext;
        cntQ   <= cntQ + 1'b1;
        if (cntQ == LAST_BIT) doneQ <= 1'b1;
      end else if (selRise) begin
        cntQ  <= '0;
        doneQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb  <= '0;
      code <= '0;
    end else begin
      stb            <= '0;
      stb.xfer       <= fireNow;
      stb.wrA        <= fireNow & b15;
      stb.bFromStage <= fireNow & b15;
      stb.wrB        <= fireNow & ~b15 & ~b12;
      stb.wrStage    <= fireNow & ~b15;
      stb.fast       <= b14;
      stb.pd         <= b13;
      if (fireNow) code <= fireWord[CODE_MSB:CODE_LSB];
    end
  end

endmodule

// File: rtl/dacfe_dp.sv
module dacfe_dp
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacfe_stb_t        stb,
  input  logic [DATA_W-1:0] code,
  output logic [DATA_W-1:0] latchA,
  output logic [DATA_W-1:0] latchB,
  output logic              fastQ,
  output logic              pdQ
);

  logic [DATA_W-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchA <= '0;
      latchB <= '0;
      stageQ <= '0;
      fastQ  <= 1'b0;
      pdQ    <= 1'b0;
    end else if (stb.xfer) begin
      if (stb.wrA)            latchA <= code;
      if (stb.wrB)            latchB <= code;
      else if (stb.bFromStage) latchB <= stageQ;
      if (stb.wrStage)        stageQ <= code;
      fastQ <= stb.fast;
      pdQ   <= stb.pd;
    end
  end

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              serClk,
  input  logic              serDin,
  output logic [DATA_W-1:0] codeA,
  output logic [DATA_W-1:0] codeB,
  output logic              fastSettle,
  output logic              powerDown
);

  dacfe_stb_t        stb;
  logic [DATA_W-1:0] code;

  dacfe_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .selN  (selN),
    .serClk(serClk),
    .serDin(serDin),
    .stb   (stb),
    .code  (code)
  );

  dacfe_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .code  (code),
    .latchA(codeA),
    .latchB(codeB),
    .fastQ (fastSettle),
    .pdQ   (powerDown)
  );

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input dacfe_stb_t        stb,
  input logic [DATA_W-1:0] code,
  input logic [DATA_W-1:0] codeA,
  input logic [DATA_W-1:0] codeB,
  input logic              fastSettle,
  input logic              powerDown
);

  assert_route_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.xfer |-> $onehot0({stb.wrA, stb.wrStage}));

  assert_load_a_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrA |=> codeA == $past(code));

  assert_load_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrB |=> (codeB == $past(code)) && $stable(codeA));

  assert_stage_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStage && !stb.wrB) |=> $stable(codeA) && $stable(codeB));

  assert_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.xfer |=> (fastSettle == $past(stb.fast)) && (powerDown == $past(stb.pd)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.xfer |=> $stable(codeA) && $stable(codeB) && $stable(fastSettle) && $stable(powerDown));

  assert_strobe_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrA || stb.wrB || stb.wrStage) |-> stb.xfer);

endmodule

bind dacfe_top dacfe_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stb       (stb),
  .code      (code),
  .codeA     (codeA),
  .codeB     (codeB),
  .fastSettle(fastSettle),
  .powerDown (powerDown)
);

// File: tb/test_dacfe_top.sv
`timescale 1ns/1ps
module test_dacfe_top;

  localparam int DW   = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1;
  logic serClk = 1'b0;
  logic serDin = 1'b0;
  logic [DW-1:0] codeA, codeB;
  logic fastSettle, powerDown;

  always #2.5 clk = ~clk;

  dacfe_top i_dacfe_top (
    .clk(clk), .rstN(rstN), .selN(selN), .serClk(serClk), .serDin(serDin),
    .codeA(codeA), .codeB(codeB), .fastSettle(fastSettle), .powerDown(powerDown)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [DW-1:0] mA = '0, mB = '0, mS = '0;
  logic mF = 1'b0, mP = 1'b0;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "codeA", int'(codeA), int'(mA));
    check(req, "codeB", int'(codeB), int'(mB));
    check(req, "fastSettle", int'(fastSettle), int'(mF));
    check(req, "powerDown", int'(powerDown), int'(mP));
  endtask

  // Reference model of one transfer (R2..R6, R1 field position).
  task automatic model(input logic [15:0] w);
    logic [DW-1:0] c;
    c = w[11:2];
    if (w[15]) begin
      mB = mS;
      mA = c;
    end else if (!w[12]) begin
      mB = c;
      mS = c;
    end else begin
      mS = c;
    end
    mF = w[14];
    mP = w[13];
  endtask

  task automatic sendFrame(input logic [15:0] w, input int nbits, input int extra,
                           input string req);
    selN = 1'b0;
    waitClk(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      serDin = w[i];
      waitClk(HALF);
      serClk = 1'b1;
      waitClk(HALF);
      serClk = 1'b0;
    end
    if (nbits == 16) begin
      model(w);
      waitClk(8);
      checkAll(req);               // R7: fired on 16th edge, select still low
      for (int e = 0; e < extra; e++) begin
        serDin = 1'($urandom);
        waitClk(HALF);
        serClk = 1'b1;
        waitClk(HALF);
        serClk = 1'b0;
      end
    end
    waitClk(HALF);
    selN = 1'b1;
    if (nbits > 0 && nbits < 16) model(w & 16'((32'd1 << nbits) - 1));
    waitClk(8);
    checkAll(req);
  endtask

  function automatic logic [15:0] mk(input logic [3:0] prog, input logic [DW-1:0] c,
                                     input logic [1:0] low);
    return {prog, c, low};
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);
    checkAll("R9");

    sendFrame(mk(4'b0000, 10'h155, 2'b11), 16, 0, "R3");
    sendFrame(mk(4'b0001, 10'h2AA, 2'b00), 16, 0, "R4");
    sendFrame(mk(4'b1000, 10'h0F0, 2'b01), 16, 0, "R2");   // both outputs change
    sendFrame(mk(4'b1001, 10'h00F, 2'b00), 16, 0, "R2");   // B stays equal to stage
    sendFrame(mk(4'b0100, 10'h3FF, 2'b10), 16, 0, "R5");
    sendFrame(mk(4'b0011, 10'h123, 2'b00), 16, 0, "R6");   // power down, codes held
    sendFrame(mk(4'b1000, 10'h0AB, 2'b00), 16, 0, "R6");   // release, B from stage
    sendFrame(mk(4'b0110, 10'h1C3, 2'b00), 16, 5, "R7");   // trailing edges ignored
    sendFrame(16'h01F4, 9, 0, "R8");
    sendFrame(16'hFFFF, 0, 0, "R8");                       // no bits, no transfer
    sendFrame(16'h3FFF, 14, 0, "R8");

    for (int k = 0; k < 60; k++) begin
      int nb;
      int ex;
      logic [15:0] w;
      w  = 16'($urandom);
      nb = ($urandom % 5 == 0) ? int'($urandom % 16) : 16;
      ex = int'($urandom % 4);
      sendFrame(w, nb, ex, "R1");
      waitClk(int'($urandom % 4));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule